// File: doc/BRIEF.md
# Three-Source Logic-Function Block Transfer Engine

This engine walks a rectangle of word-organised image memory, fetching up to three source words per position (channels A, B and C). It combines them bit by bit through an 8-bit truth table and stores the result through a fourth channel, D. Any Boolean function of three inputs can be chosen this way. The usual job is compositing a game object over a background: one source acts as a stencil that picks, for each pixel bit, either the object bit or the background bit.

Software loads four pointers, four signed row modulos, the rectangle size, the function byte and the channel enables through a small register write port, then writes the start register. The engine then owns a 16-bit memory port until the last destination word is written, when it drops busy and pulses done. An optional fill mode walks each row from right to left. It turns single-pixel-wide outlines into solid spans using a parity carry.

Top module: `blt_engine`

## Requirements
- R1: Each result bit i equals bit {A[i],B[i],C[i]} of the function byte, with A as the most significant index bit, so 0xCA yields A ? B : C and 0xF0 copies A.
- R2: A source whose enable bit is clear is never read from memory and contributes all zeros. Each word position issues exactly one read per enabled source, in the order A, B, C.
- R3: When the destination enable is clear, no memory write is issued, yet the operation still runs to the end and pulses done.
- R4: The rectangle is width words by height rows. Outside fill mode, every channel pointer advances by +1 after each word position. After the last word of a row, the channel's 18-bit signed modulo is also added, with wrap-around.
- R5: In fill mode, pointers step by -1 per word. Within a word, bits are taken from bit 0 upward, and the carry passes to the next word of the same row. The carry is 0 at the start of every row. Each output bit is result OR carry, and the carry then toggles on every result bit that is 1.
- R6: busy is high in the cycle after the start write. done is a one-cycle pulse in the same cycle busy falls, after the last destination word is written.
- R7: A start with width 0 or height 0 makes no memory access. busy stays high for one cycle, then done pulses.
- R8: Register writes, including start, are ignored while busy. The running operation and the next one both use the values loaded before the start.
- R9: A memory request holds its address, direction and write data until granted. Read data is taken in the cycle the grant is present.
- R10: After reset, busy, done and mem_req are all low.
- R11: Register addresses: 0-3 pointers of A, B, C, D; 4-7 modulos of A, B, C, D; 8 width; 9 height; 10 control with function in bits 7:0, enables A, B, C, D in bits 8, 9, 10, 11 and fill in bit 12; 11 start, triggered by a write with bit 0 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | RAW (4) | Register address |
| cfg_wdata | input | RW (32) | Register write data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW (18) | Word address |
| mem_wdata | output | DW (16) | Write data |
| mem_gnt | input | 1 | Grant; completes the current access |
| mem_rdata | input | DW (16) | Read data, valid with grant |

## Verification
The bench models the whole rectangle walk with random grant stalls and compares every memory word afterwards. A wrong minterm index order would corrupt the stencil and random function cases. A missed modulo, or a wrong pointer direction, would write outside the destination area, and so would rows walked upward with negative modulos. In fill mode, a carry that is not cleared per row, or that is not chained across words, would smear filled spans into the next row or stop them at word borders. Zero-size starts, a disabled destination and writes arriving mid-operation are each checked through the read and write counts and the done pulse. A design that fetched disabled sources, or let a start or register write through while busy, would show up in those counts or in the untouched memory.

// File: rtl/blt_pkg.sv
package blt_pkg;
   localparam int unsigned NCH  = 4;
   localparam int unsigned CH_A = 0;
   localparam int unsigned CH_B = 1;
   localparam int unsigned CH_C = 2;
   localparam int unsigned CH_D = 3;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SRC_A,
      ST_SRC_B,
      ST_SRC_C,
      ST_DST,
      ST_END
   } blt_state_e;
endpackage

// File: rtl/blt_regs.sv
module blt_regs
   import blt_pkg::*;
#(
   parameter int AW  = 18,
   parameter int CW  = 10,
   parameter int RW  = 32,
   parameter int RAW = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     we,
   input  logic [RAW-1:0]           addr,
   input  logic [RW-1:0]            wdata,
   input  logic                     busy,
   output logic [NCH-1:0][AW-1:0]   ptr_o,
   output logic [NCH-1:0][AW-1:0]   mod_o,
   output logic [CW-1:0]            width_o,
   output logic [CW-1:0]            height_o,
   output logic [7:0]               func_o,
   output logic [NCH-1:0]           en_o,
   output logic                     fill_o,
   output logic                     start_o
);
   localparam logic [RAW-1:0] A_WIDTH  = RAW'(8);
   localparam logic [RAW-1:0] A_HEIGHT = RAW'(9);
   localparam logic [RAW-1:0] A_CTRL   = RAW'(10);
   localparam logic [RAW-1:0] A_START  = RAW'(11);
   localparam int             CTL_W    = 8 + NCH + 1;

   logic [NCH-1:0][AW-1:0] ptr_q, mod_q;
   logic [CW-1:0]          width_q, height_q;
   logic [CTL_W-1:0]       ctrl_q;
   logic                   wr_ok;

   assign wr_ok = we && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q    <= '0;
         mod_q    <= '0;
         width_q  <= '0;
         height_q <= '0;
         ctrl_q   <= '0;
      end else if (wr_ok) begin
         if (addr[RAW-1:2] == '0)
            ptr_q[addr[1:0]] <= wdata[AW-1:0];
         else if (addr[RAW-1:2] == (RAW-2)'(1))
            mod_q[addr[1:0]] <= wdata[AW-1:0];
         else if (addr == A_WIDTH)
            width_q <= wdata[CW-1:0];
         else if (addr == A_HEIGHT)
            height_q <= wdata[CW-1:0];
         else if (addr == A_CTRL)
            ctrl_q <= wdata[CTL_W-1:0];
      end
   end

   generate
      if (RW > AW) begin : g_spare
         logic unused_wdata;
         assign unused_wdata = ^wdata[RW-1:AW];
      end
   endgenerate

   assign ptr_o    = ptr_q;
   assign mod_o    = mod_q;
   assign width_o  = width_q;
   assign height_o = height_q;
   assign func_o   = ctrl_q[7:0];
   assign en_o     = ctrl_q[8 +: NCH];
   assign fill_o   = ctrl_q[8 + NCH];
   assign start_o  = wr_ok && (addr == A_START) && wdata[0];

   p_cfg_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(busy) |-> ($stable(ctrl_q) && $stable(ptr_q) && $stable(mod_q)
                       && $stable(width_q) && $stable(height_q)));
endmodule

// File: rtl/blt_chan.sv
module blt_chan #(
   parameter int AW = 18
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] base,
   input  logic          adv,
   input  logic          dec,
   input  logic          eol,
   input  logic [AW-1:0] modulo,
   output logic [AW-1:0] ptr
);
   logic [AW-1:0] step, extra;

   assign step  = dec ? '1 : AW'(1);
   assign extra = eol ? modulo : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ptr <= '0;
      else if (load)  ptr <= base;
      else if (adv)   ptr <= ptr + step + extra;
   end

   p_ptr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !adv) |=> $stable(ptr));
endmodule

// File: rtl/blt_logic.sv
module blt_logic #(
   parameter int DW = 16
) (
   input  logic [DW-1:0] a,
   input  logic [DW-1:0] b,
   input  logic [DW-1:0] c,
   input  logic [7:0]    func,
   output logic [DW-1:0] res
);
   generate
      for (genvar i = 0; i < DW; i++) begin : g_bit
         assign res[i] = func[{a[i], b[i], c[i]}];
      end
   endgenerate
endmodule

// File: rtl/blt_fill.sv
module blt_fill #(
   parameter int DW      = 16,
   parameter int FILL_EN = 1
) (
   input  logic [DW-1:0] res,
   input  logic          fill,
   input  logic          cin,
   output logic [DW-1:0] out,
   output logic          cout
);
   generate
      if (FILL_EN != 0) begin : g_fill
         logic [DW-1:0] spread;
         logic          par;
         always_comb begin
            par = cin;
            for (int i = 0; i < DW; i++) begin
               spread[i] = res[i] | par;
               par       = par ^ res[i];
            end
         end
         assign out  = fill ? spread : res;
         assign cout = fill ? par : 1'b0;
      end else begin : g_plain
         logic unused_fill;
         assign unused_fill = fill ^ cin;
         assign out  = res;
         assign cout = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/blt_engine.sv
module blt_engine
   import blt_pkg::*;
#(
   parameter int DW      = 16,
   parameter int AW      = 18,
   parameter int CW      = 10,
   parameter int RW      = 32,
   parameter int RAW     = 4,
   parameter int FILL_EN = 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           cfg_we,
   input  logic [RAW-1:0] cfg_addr,
   input  logic [RW-1:0]  cfg_wdata,
   output logic           busy,
   output logic           done,
   output logic           mem_req,
   output logic           mem_we,
   output logic [AW-1:0]  mem_addr,
   output logic [DW-1:0]  mem_wdata,
   input  logic           mem_gnt,
   input  logic [DW-1:0]  mem_rdata
);
   if (DW < 2)        begin : g_bad_dw  $error("DW too small"); end
   if (AW > RW)       begin : g_bad_aw  $error("AW exceeds RW"); end
   if (CW > RW)       begin : g_bad_cw  $error("CW exceeds RW"); end
   if (RAW < 4)       begin : g_bad_raw $error("RAW below 4"); end

   logic [NCH-1:0][AW-1:0] base, modv, ptr;
   logic [CW-1:0]          width, height, col, row;
   logic [7:0]             func;
   logic [NCH-1:0]         en;
   logic                   fill_cfg, fill_eff, start;
   blt_state_e             st;
   logic [DW-1:0]          da, db, dc, res;
   logic                   carry, cin, cout, step_ok, adv, eol, zero_size;

   blt_regs #(.AW(AW), .CW(CW), .RW(RW), .RAW(RAW)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
      .busy(busy), .ptr_o(base), .mod_o(modv), .width_o(width), .height_o(height),
      .func_o(func), .en_o(en), .fill_o(fill_cfg), .start_o(start));

   assign fill_eff = (FILL_EN != 0) && fill_cfg;

   generate
      for (genvar k = 0; k < NCH; k++) begin : g_chan
         blt_chan #(.AW(AW)) u_chan (
            .clk(clk), .rst_n(rst_n), .load(start), .base(base[k]), .adv(adv),
            .dec(fill_eff), .eol(eol), .modulo(modv[k]), .ptr(ptr[k]));
      end
   endgenerate

   blt_logic #(.DW(DW)) u_logic (.a(da), .b(db), .c(dc), .func(func), .res(res));

   blt_fill #(.DW(DW), .FILL_EN(FILL_EN)) u_fill (
      .res(res), .fill(fill_eff), .cin(cin), .out(mem_wdata), .cout(cout));

   always_comb begin
      mem_req  = 1'b0;
      mem_addr = ptr[CH_D];
      case (st)
         ST_SRC_A: begin mem_req = en[CH_A]; mem_addr = ptr[CH_A]; end
         ST_SRC_B: begin mem_req = en[CH_B]; mem_addr = ptr[CH_B]; end
         ST_SRC_C: begin mem_req = en[CH_C]; mem_addr = ptr[CH_C]; end
         ST_DST:   begin mem_req = en[CH_D]; mem_addr = ptr[CH_D]; end
         default:  ;
      endcase
   end

   assign mem_we    = (st == ST_DST);
   assign busy      = (st != ST_IDLE);
   assign step_ok   = !mem_req || mem_gnt;
   assign adv       = (st == ST_DST) && step_ok;
   assign eol       = (col == width - 1'b1);
   assign cin       = (col == '0) ? 1'b0 : carry;
   assign zero_size = (width == '0) || (height == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= ST_IDLE;
         done  <= 1'b0;
         col   <= '0;
         row   <= '0;
         carry <= 1'b0;
         da    <= '0;
         db    <= '0;
         dc    <= '0;
      end else begin
         done <= 1'b0;
         case (st)
            ST_IDLE: if (start) begin
               col   <= '0;
               row   <= '0;
               carry <= 1'b0;
               st    <= zero_size ? ST_END : ST_SRC_A;
            end
            ST_SRC_A: if (step_ok) begin
               da <= en[CH_A] ? mem_rdata : '0;
               st <= ST_SRC_B;
            end
            ST_SRC_B: if (step_ok) begin
               db <= en[CH_B] ? mem_rdata : '0;
               st <= ST_SRC_C;
            end
            ST_SRC_C: if (step_ok) begin
               dc <= en[CH_C] ? mem_rdata : '0;
               st <= ST_DST;
            end
            ST_DST: if (step_ok) begin
               carry <= cout;
               if (eol) begin
                  col <= '0;
                  if (row == height - 1'b1) begin
                     st   <= ST_IDLE;
                     done <= 1'b1;
                  end else begin
                     row <= row + 1'b1;
                     st  <= ST_SRC_A;
                  end
               end else begin
                  col <= col + 1'b1;
                  st  <= ST_SRC_A;
               end
            end
            ST_END: begin
               st   <= ST_IDLE;
               done <= 1'b1;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                 && $stable(mem_wdata)));
   p_no_req_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_req);
   p_done_at_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));
   p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_no_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> en[CH_D]);
endmodule

// File: tb/sim_blt_engine.sv
module sim_blt_engine;
   localparam int DW = 16, AW = 18, CW = 10, RW = 32, RAW = 4, MD = 4096, PITCH = 8;

   logic clk = 1'b0, rst_n = 1'b0;
   always #2 clk = ~clk;

   logic           cfg_we = 1'b0;
   logic [RAW-1:0] cfg_addr = '0;
   logic [RW-1:0]  cfg_wdata = '0;
   logic busy, done, mem_req, mem_we, mem_gnt = 1'b0;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata, mem_rdata;

   logic [DW-1:0] mem [MD];
   logic [DW-1:0] exp_mem [MD];

   blt_engine u0 (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .busy(busy), .done(done), .mem_req(mem_req),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_gnt(mem_gnt), .mem_rdata(mem_rdata));

   int n_chk = 0, n_fail = 0, cyc = 0;
   int rd_cnt = 0, wr_cnt = 0, dn_cnt = 0;
   int exp_rd, exp_wr;
   bit stall = 1'b1;

   logic [AW-1:0] cfg_p [4];
   logic [AW-1:0] cfg_m [4];
   int            cfg_w, cfg_h;
   logic [7:0]    cfg_f;
   logic [3:0]    cfg_en;
   logic          cfg_fl;

   assign mem_rdata = mem[mem_addr[11:0]];

   always @(posedge clk) begin
      cyc++;
      if (mem_req && mem_gnt) begin
         if (mem_we) begin mem[mem_addr[11:0]] <= mem_wdata; wr_cnt++; end
         else rd_cnt++;
      end
   end
   always @(negedge clk) begin
      if (done) dn_cnt++;
      mem_gnt <= mem_req && (!stall || ($urandom % 3 != 0));
   end

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   always @(posedge clk) if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      summary();
   end

   task automatic chk(input bit ok, input string req, input longint act, input longint expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   task automatic wr(input int a, input logic [RW-1:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = RAW'(a); cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   // R11: register map programming
   task automatic program_regs();
      for (int i = 0; i < 4; i++) wr(i, RW'(cfg_p[i]));
      for (int i = 0; i < 4; i++) wr(4 + i, RW'(cfg_m[i]));
      wr(8, RW'(cfg_w));
      wr(9, RW'(cfg_h));
      wr(10, {19'b0, cfg_fl, cfg_en, cfg_f});
   endtask

   // Reference walk built from R1, R2, R4, R5
   task automatic ref_run();
      logic [AW-1:0] pp [4];
      logic [DW-1:0] sv [3];
      logic [DW-1:0] o;
      logic rb, cy;
      for (int k = 0; k < MD; k++) exp_mem[k] = mem[k];
      for (int i = 0; i < 4; i++) pp[i] = cfg_p[i];
      exp_rd = 0; exp_wr = 0;
      if (cfg_w != 0 && cfg_h != 0)
         for (int r = 0; r < cfg_h; r++) begin
            cy = 1'b0;
            for (int c = 0; c < cfg_w; c++) begin
               for (int s = 0; s < 3; s++) begin
                  sv[s] = cfg_en[s] ? exp_mem[pp[s][11:0]] : '0;
                  if (cfg_en[s]) exp_rd++;
               end
               for (int b = 0; b < DW; b++) begin
                  rb = cfg_f[{sv[0][b], sv[1][b], sv[2][b]}];
                  if (cfg_fl) begin o[b] = rb | cy; cy = cy ^ rb; end
                  else o[b] = rb;
               end
               if (cfg_en[3]) begin exp_mem[pp[3][11:0]] = o; exp_wr++; end
               for (int i = 0; i < 4; i++) begin
                  pp[i] = pp[i] + (cfg_fl ? '1 : AW'(1));
                  if (c == cfg_w - 1) pp[i] = pp[i] + cfg_m[i];
               end
            end
         end
   endtask

   task automatic layout(input int w, input int h, input logic fl, input bit up);
      int bases [4] = '{32'h100, 32'h300, 32'h500, 32'h800};
      cfg_w = w; cfg_h = h; cfg_fl = fl;
      for (int i = 0; i < 4; i++) begin
         if (fl) begin
            cfg_p[i] = AW'(bases[i] + w - 1); cfg_m[i] = AW'(PITCH + w);
         end else if (up) begin
            cfg_p[i] = AW'(bases[i] + PITCH * (h - 1)); cfg_m[i] = AW'(-PITCH - w);
         end else begin
            cfg_p[i] = AW'(bases[i]); cfg_m[i] = AW'(PITCH - w);
         end
      end
   endtask

   task automatic start_op(input string tag);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = RAW'(11); cfg_wdata = 1;
      @(negedge clk);
      cfg_we = 1'b0;
      chk(busy === 1'b1, {tag, " R6 busy after start"}, busy, 1);
   endtask

   task automatic finish_op(input string tag, input int rd0, input int wr0, input int dn0);
      int bad;
      int first;
      for (int t = 0; t < 5000 && busy; t++) @(negedge clk);
      chk(done === 1'b1, {tag, " R6 done with busy fall"}, done, 1);
      @(negedge clk);
      bad = 0; first = -1;
      for (int k = 0; k < MD; k++)
         if (mem[k] !== exp_mem[k]) begin bad++; if (first < 0) first = k; end
      if (bad != 0)
         chk(1'b0, {tag, " R1 R4 R5 R9 memory image"}, mem[first], exp_mem[first]);
      else chk(1'b1, tag, 0, 0);
      chk(rd_cnt - rd0 == exp_rd, {tag, " R2 read count"}, rd_cnt - rd0, exp_rd);
      chk(wr_cnt - wr0 == exp_wr, {tag, " R3 write count"}, wr_cnt - wr0, exp_wr);
      chk(dn_cnt - dn0 == 1, {tag, " R6 one done pulse"}, dn_cnt - dn0, 1);
   endtask

   task automatic run(input string tag);
      int rd0, wr0, dn0;
      program_regs();
      ref_run();
      rd0 = rd_cnt; wr0 = wr_cnt; dn0 = dn_cnt;
      start_op(tag);
      finish_op(tag, rd0, wr0, dn0);
   endtask

   initial begin
      int rd0, wr0, dn0;
      void'($urandom(32'd1234));
      for (int k = 0; k < MD; k++) mem[k] = DW'($urandom);
      repeat (3) @(negedge clk);
      // R10: reset state
      chk(busy === 1'b0 && done === 1'b0 && mem_req === 1'b0, "R10 reset outputs",
          {busy, done, mem_req}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy === 1'b0 && mem_req === 1'b0, "R10 idle after reset", {busy, mem_req}, 0);

      // R1: stencil select A ? B : C
      layout(3, 4, 1'b0, 1'b0); cfg_f = 8'hCA; cfg_en = 4'hF;
      run("R1 stencil");

      // R2: copy A only, B and C disabled
      layout(4, 2, 1'b0, 1'b0); cfg_f = 8'hF0; cfg_en = 4'b1001;
      run("R2 copy A");

      // R4: negative modulos, rows walked upward
      layout(2, 3, 1'b0, 1'b1); cfg_f = 8'h96; cfg_en = 4'hF;
      run("R4 upward");

      // R5: fill from an outline pair spanning a word border
      layout(2, 3, 1'b1, 1'b0); cfg_f = 8'hF0; cfg_en = 4'b1001;
      for (int r = 0; r < 3; r++) begin
         mem[12'h100 + r * PITCH]     = 16'h0010;
         mem[12'h100 + r * PITCH + 1] = 16'h0800 | DW'(r == 1);
      end
      run("R5 fill");

      // R3: destination disabled
      layout(3, 2, 1'b0, 1'b0); cfg_f = 8'hFF; cfg_en = 4'b0111;
      run("R3 no dest");

      // R7: zero width
      layout(0, 3, 1'b0, 1'b0); cfg_f = 8'hFF; cfg_en = 4'hF;
      program_regs(); ref_run();
      rd0 = rd_cnt; wr0 = wr_cnt; dn0 = dn_cnt;
      start_op("R7 zero width");
      @(negedge clk);
      chk(busy === 1'b0 && done === 1'b1, "R7 one busy cycle", {busy, done}, 1);
      chk(rd_cnt == rd0 && wr_cnt == wr0, "R7 no access", rd_cnt - rd0 + wr_cnt - wr0, 0);

      // R7: zero height
      layout(2, 0, 1'b0, 1'b0);
      run("R7 zero height");

      // R8: writes while busy are ignored
      layout(4, 3, 1'b0, 1'b0); cfg_f = 8'hE4; cfg_en = 4'hF;
      program_regs(); ref_run();
      rd0 = rd_cnt; wr0 = wr_cnt; dn0 = dn_cnt;
      start_op("R8 run");
      wr(10, {19'b0, 1'b1, 4'hF, 8'h00});
      wr(3, RW'(32'hA00));
      wr(11, 1);
      finish_op("R8 run", rd0, wr0, dn0);
      ref_run();
      rd0 = rd_cnt; wr0 = wr_cnt; dn0 = dn_cnt;
      start_op("R8 rerun");
      finish_op("R8 rerun", rd0, wr0, dn0);

      // R9: no stalls, then random operations with stalls
      stall = 1'b0;
      layout(3, 3, 1'b0, 1'b0); cfg_f = 8'h6A; cfg_en = 4'hF;
      run("R9 no stall");
      stall = 1'b1;
      for (int n = 0; n < 10; n++) begin
         layout(1 + $urandom % 4, 1 + $urandom % 4, 1'($urandom), 1'($urandom));
         cfg_f = 8'($urandom);
         cfg_en = {1'b1, 3'($urandom)};
         run("R1 R5 random");
      end
      summary();
   end
endmodule